// File: doc/BRIEF.md
# Multi-Mode Linear Address Translator

This block turns a 32-bit linear address into a physical address of up to 36 bits. It does this by walking hierarchical page tables that sit in memory. Three flags, taken from control-register values written through a common strobe, choose how it works. With the enable flag clear it does no translation. With it set, the block uses 4 KB pages, large directory-level pages, or an extended layout with 8-byte entries and an extra pointer level above the directory.

A translation cache of eight entries, fully associative, holds recent results together with their page size, so 4 KB and large mappings can sit side by side. A hit returns its answer without touching memory. On a miss, a walker state machine reads one table entry at a time over a simple request/valid port. It then returns a physical address, or a fault when it meets an entry whose present bit is clear.

The block takes one request at a time. Writing the control registers, or pulsing the flush input, empties the cache.

Top module: `lin_xlate`

## Requirements
- R1: While bit 31 of the control-0 value is clear, the response physical address equals the linear address with zeros above it, no fault is reported and no memory read is issued.
- R2: In normal mode (bit 31 set, bit 5 of control-4 clear), a 4 KB walk makes two 4-byte reads. The directory read is at root[31:12]*4096 + lin[31:22]*4 and the table read is at entry[31:12]*4096 + lin[21:12]*4. The result is {entry[31:12], lin[11:0]}.
- R3: With bit 4 of control-4 set and extended mode off, a directory entry with bit 7 set ends the walk after one read. The result is {entry[31:22], lin[21:0]}.
- R4: While bit 4 of control-4 is clear, bit 7 of a directory entry is ignored and the walk continues to the table level.
- R5: In extended mode (bits 31 and 5 set), a 4 KB walk makes three 8-byte reads. The pointer read is at root[31:5]*32 + lin[31:30]*8, the directory read at entry[35:12]*4096 + lin[29:21]*8 and the table read at entry[35:12]*4096 + lin[20:12]*8. The result is {entry[35:12], lin[11:0]}.
- R6: In extended mode with bit 4 set, a directory entry with bit 7 set gives a 2 MB page after two reads. The result is {entry[35:21], lin[20:0]}.
- R7: An entry with bit 0 clear, at any level, ends the walk. The response has the fault flag set and address zero, and nothing is stored in the cache, so a repeat of the same address walks again.
- R8: A repeat translation covered by a cached mapping, including another offset inside a cached large page, returns the same result with no memory read.
- R9: The cache holds 8 mappings and replaces them in round-robin order, starting from slot 0 after an invalidation. The ninth new mapping evicts the first.
- R10: A control write strobe or a flush pulse invalidates every cached mapping at the next clock edge.
- R11: Only one translation is in flight at a time. The ready output stays low from acceptance up to and including the response cycle, and at most one memory read is outstanding.
- R12: The extended-mode flag has no effect while bit 31 of control-0 is clear, so the address passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Strobe that loads the three control values and flushes the cache |
| ctl0_in | input | 32 | Control-0 value; bit 31 enables translation |
| ctl3_in | input | 32 | Table root address |
| ctl4_in | input | 32 | Control-4 value; bit 4 enables large pages, bit 5 enables extended mode |
| flush | input | 1 | Invalidate all cached mappings |
| req_valid | input | 1 | Translation request |
| req_lin | input | 32 | Linear address |
| req_ready | output | 1 | Block is idle and will accept a request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Not-present fault |
| rsp_phys | output | 36 | Physical address |
| mem_req | output | 1 | One-cycle table-entry read request |
| mem_addr | output | 36 | Byte address of the entry |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Entry data; only the low 32 bits are used in normal mode |

## Verification
A wrong cache state shows up first as a change in read count. A mapping that should still be cached costs a full walk of two or three reads. A stale mapping that should have been flushed answers with no read and returns the wrong physical address within two cycles of acceptance. A walker that latches the wrong level or mode puts a wrong value on mem_addr at its very next read, and so returns a wrong address or a fault instead of a result. A broken round-robin pointer only shows after eight fills, which is why the bench refills the cache past its depth before it checks which pages still hit.

// File: rtl/xl_pkg.sv
package xl_pkg;
    localparam int LIN_W   = 32;
    localparam int PHY_W   = 36;
    localparam int ENT_W   = 64;
    localparam int PG_BIT  = 31;
    localparam int PSE_BIT = 4;
    localparam int PAE_BIT = 5;
    localparam int OFF_W   = 12;

    typedef enum logic [1:0] {
        SZ_4K = 2'd0,
        SZ_2M = 2'd1,
        SZ_4M = 2'd2
    } pgsz_e;

    typedef enum logic [2:0] {
        W_IDLE  = 3'd0,
        W_LOOK  = 3'd1,
        W_ISSUE = 3'd2,
        W_WAIT  = 3'd3,
        W_RESP  = 3'd4
    } wst_e;

    typedef struct packed {
        logic             pg;
        logic             pse;
        logic             pae;
        logic [LIN_W-1:0] root;
    } mode_t;
endpackage

// File: rtl/xl_ctl.sv
module xl_ctl
    import xl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [LIN_W-1:0] ctl0_in,
    input  logic [LIN_W-1:0] ctl3_in,
    input  logic [LIN_W-1:0] ctl4_in,
    input  logic             flush,
    output mode_t            mode,
    output logic             inv
);
    mode_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (ctl_wr) begin
            m_d.pg   = ctl0_in[PG_BIT];
            m_d.pse  = ctl4_in[PSE_BIT];
            m_d.pae  = ctl4_in[PAE_BIT];
            m_d.root = ctl3_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign mode = m_q;
    assign inv  = ctl_wr | flush;

    logic unused_ctl_bits;
    assign unused_ctl_bits = ^{ctl0_in[PG_BIT-1:0], ctl4_in[LIN_W-1:PAE_BIT+1], ctl4_in[PSE_BIT-1:0]};

    // R12: a freshly written mode never leaves translation off with a stale root change visible
    a_r12_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (m_q.pg == $past(ctl0_in[PG_BIT])) && (m_q.pae == $past(ctl4_in[PAE_BIT])));
endmodule

// File: rtl/xl_tcache.sv
module xl_tcache
    import xl_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inv,
    input  logic [LIN_W-1:0] look_lin,
    output logic             hit,
    output logic [PHY_W-1:0] hit_phys,
    input  logic             fill_en,
    input  logic [LIN_W-1:0] fill_lin,
    input  pgsz_e            fill_sz,
    input  logic [PHY_W-1:0] fill_phys
);
    localparam int IDXW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int VPN_W = LIN_W - OFF_W;
    localparam int PPN_W = PHY_W - OFF_W;

    typedef struct packed {
        logic [DEPTH-1:0]             vld;
        logic [DEPTH-1:0][VPN_W-1:0]  vpn;
        logic [DEPTH-1:0][PPN_W-1:0]  ppn;
        logic [DEPTH-1:0][1:0]        sz;
        logic [IDXW-1:0]              ptr;
    } tc_t;

    tc_t d, q;

    function automatic logic [PHY_W-1:0] off_mask(input logic [1:0] s);
        case (s)
            SZ_2M:   off_mask = PHY_W'(36'h0_001F_FFFF);
            SZ_4M:   off_mask = PHY_W'(36'h0_003F_FFFF);
            default: off_mask = PHY_W'(36'h0_0000_0FFF);
        endcase
    endfunction

    logic [DEPTH-1:0]            match;
    logic [DEPTH-1:0][PHY_W-1:0] om;
    logic [PHY_W-1:0]            lin_x;

    assign lin_x = {{(PHY_W-LIN_W){1'b0}}, look_lin};

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        assign om[g]    = off_mask(q.sz[g]);
        assign match[g] = q.vld[g] &&
            (((q.vpn[g] ^ look_lin[LIN_W-1:OFF_W]) & ~om[g][LIN_W-1:OFF_W]) == '0);
    end

    always_comb begin
        hit_phys = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i])
                hit_phys = hit_phys | (({q.ppn[i], {OFF_W{1'b0}}} & ~om[i]) | (lin_x & om[i]));
        end
    end
    assign hit = |match;

    always_comb begin
        d = q;
        if (inv) begin
            d.vld = '0;
            d.ptr = '0;
        end else if (fill_en) begin
            d.vld[q.ptr] = 1'b1;
            d.vpn[q.ptr] = fill_lin[LIN_W-1:OFF_W];
            d.ppn[q.ptr] = fill_phys[PHY_W-1:OFF_W];
            d.sz[q.ptr]  = fill_sz;
            d.ptr        = (q.ptr == IDXW'(DEPTH-1)) ? '0 : q.ptr + IDXW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    logic unused_fill_bits;
    assign unused_fill_bits = ^fill_phys[OFF_W-1:0];

    a_r10_flush_all: assert property (@(posedge clk) disable iff (!rst_n)
        inv |=> (q.vld == '0) && (q.ptr == '0));
    a_r8_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
    a_r9_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !inv && q.ptr == IDXW'(DEPTH-1)) |=> (q.ptr == '0));
    a_r9_fill_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !inv) |=> ($countones(q.vld) >= 1));
endmodule

// File: rtl/xl_walker.sv
module xl_walker
    import xl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  mode_t            mode,
    input  logic             inv,
    input  logic             req_valid,
    input  logic [LIN_W-1:0] req_lin,
    output logic             req_ready,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic [PHY_W-1:0] rsp_phys,
    output logic             mem_req,
    output logic [PHY_W-1:0] mem_addr,
    input  logic             mem_rvalid,
    input  logic [ENT_W-1:0] mem_rdata,
    output logic [LIN_W-1:0] look_lin,
    input  logic             hit,
    input  logic [PHY_W-1:0] hit_phys,
    output logic             fill_en,
    output logic [LIN_W-1:0] fill_lin,
    output pgsz_e            fill_sz,
    output logic [PHY_W-1:0] fill_phys
);
    localparam int XW = PHY_W - LIN_W;

    typedef struct packed {
        wst_e             st;
        logic [1:0]       lvl;
        logic [LIN_W-1:0] lin;
        logic [LIN_W-1:0] root;
        logic [PHY_W-1:0] addr;
        logic [PHY_W-1:0] phys;
        logic             pg;
        logic             pse;
        logic             ext;
        logic             fault;
        logic             stale;
    } wk_t;

    wk_t d, q;
    logic [ENT_W-1:0] e;

    always_comb begin
        d         = q;
        fill_en   = 1'b0;
        fill_sz   = SZ_4K;
        e         = q.ext ? mem_rdata : {{(ENT_W-32){1'b0}}, mem_rdata[31:0]};
        if (inv && q.st != W_IDLE) d.stale = 1'b1;
        case (q.st)
            W_IDLE: begin
                if (req_valid) begin
                    d.st    = W_LOOK;
                    d.lin   = req_lin;
                    d.pg    = mode.pg;
                    d.pse   = mode.pse;
                    d.ext   = mode.pg & mode.pae;
                    d.root  = mode.root;
                    d.fault = 1'b0;
                    d.stale = 1'b0;
                end
            end
            W_LOOK: begin
                if (!q.pg) begin
                    d.phys = {{XW{1'b0}}, q.lin};
                    d.st   = W_RESP;
                end else if (hit) begin
                    d.phys = hit_phys;
                    d.st   = W_RESP;
                end else if (q.ext) begin
                    d.addr = {{XW{1'b0}}, q.root[31:5], q.lin[31:30], 3'b000};
                    d.lvl  = 2'd0;
                    d.st   = W_ISSUE;
                end else begin
                    d.addr = {{XW{1'b0}}, q.root[31:12], q.lin[31:22], 2'b00};
                    d.lvl  = 2'd1;
                    d.st   = W_ISSUE;
                end
            end
            W_ISSUE: d.st = W_WAIT;
            W_WAIT: begin
                if (mem_rvalid) begin
                    if (!e[0]) begin
                        d.fault = 1'b1;
                        d.phys  = '0;
                        d.st    = W_RESP;
                    end else begin
                        case (q.lvl)
                            2'd0: begin
                                d.addr = {e[35:12], q.lin[29:21], 3'b000};
                                d.lvl  = 2'd1;
                                d.st   = W_ISSUE;
                            end
                            2'd1: begin
                                if (q.pse && e[7]) begin
                                    if (q.ext) begin
                                        d.phys  = {e[35:21], q.lin[20:0]};
                                        fill_sz = SZ_2M;
                                    end else begin
                                        d.phys  = {{XW{1'b0}}, e[31:22], q.lin[21:0]};
                                        fill_sz = SZ_4M;
                                    end
                                    fill_en = !q.stale;
                                    d.st    = W_RESP;
                                end else begin
                                    d.addr = q.ext ? {e[35:12], q.lin[20:12], 3'b000}
                                                   : {{XW{1'b0}}, e[31:12], q.lin[21:12], 2'b00};
                                    d.lvl  = 2'd2;
                                    d.st   = W_ISSUE;
                                end
                            end
                            default: begin
                                d.phys  = q.ext ? {e[35:12], q.lin[11:0]}
                                                : {{XW{1'b0}}, e[31:12], q.lin[11:0]};
                                fill_sz = SZ_4K;
                                fill_en = !q.stale;
                                d.st    = W_RESP;
                            end
                        endcase
                    end
                end
            end
            W_RESP:  d.st = W_IDLE;
            default: d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready = (q.st == W_IDLE);
    assign rsp_valid = (q.st == W_RESP);
    assign rsp_fault = q.fault;
    assign rsp_phys  = q.phys;
    assign mem_req   = (q.st == W_ISSUE);
    assign mem_addr  = q.addr;
    assign look_lin  = q.lin;
    assign fill_lin  = q.lin;
    assign fill_phys = d.phys;

    logic unused_walk_bits;
    assign unused_walk_bits = ^{e[ENT_W-1:PHY_W], e[11:8], e[6:1], q.root[4:0]};

    a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    a_r11_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    a_r1_no_read_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> q.pg);
    a_r7_no_fill_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |-> (mem_rvalid && e[0]));
    a_r8_hit_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == W_LOOK && q.pg && hit) |=> (rsp_valid && !mem_req));
endmodule

// File: rtl/lin_xlate.sv
module lin_xlate
    import xl_pkg::*;
#(
    parameter int TC_DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [LIN_W-1:0] ctl0_in,
    input  logic [LIN_W-1:0] ctl3_in,
    input  logic [LIN_W-1:0] ctl4_in,
    input  logic             flush,
    input  logic             req_valid,
    input  logic [LIN_W-1:0] req_lin,
    output logic             req_ready,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic [PHY_W-1:0] rsp_phys,
    output logic             mem_req,
    output logic [PHY_W-1:0] mem_addr,
    input  logic             mem_rvalid,
    input  logic [ENT_W-1:0] mem_rdata
);
    mode_t            mode;
    logic             inv;
    logic [LIN_W-1:0] look_lin;
    logic             hit;
    logic [PHY_W-1:0] hit_phys;
    logic             fill_en;
    logic [LIN_W-1:0] fill_lin;
    pgsz_e            fill_sz;
    logic [PHY_W-1:0] fill_phys;

    xl_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl0_in(ctl0_in),
        .ctl3_in(ctl3_in), .ctl4_in(ctl4_in), .flush(flush),
        .mode(mode), .inv(inv)
    );

    xl_tcache #(.DEPTH(TC_DEPTH)) u_tc (
        .clk(clk), .rst_n(rst_n), .inv(inv), .look_lin(look_lin),
        .hit(hit), .hit_phys(hit_phys), .fill_en(fill_en), .fill_lin(fill_lin),
        .fill_sz(fill_sz), .fill_phys(fill_phys)
    );

    xl_walker u_walk (
        .clk(clk), .rst_n(rst_n), .mode(mode), .inv(inv),
        .req_valid(req_valid), .req_lin(req_lin), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_phys(rsp_phys),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .look_lin(look_lin), .hit(hit), .hit_phys(hit_phys),
        .fill_en(fill_en), .fill_lin(fill_lin), .fill_sz(fill_sz), .fill_phys(fill_phys)
    );

    // R7: a faulting response never carries an address
    a_r7_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_phys == '0));
endmodule

// File: tb/lin_xlate_tb.sv
module lin_xlate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [31:0] ctl0_in = '0, ctl3_in = '0, ctl4_in = '0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_lin = '0;
    logic        req_ready, rsp_valid, rsp_fault, mem_req;
    logic [35:0] rsp_phys, mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;

    int checks = 0, errors = 0, nreads = 0, busy_viol = 0;

    always #10 clk = ~clk;

    lin_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl0_in(ctl0_in),
        .ctl3_in(ctl3_in), .ctl4_in(ctl4_in), .flush(flush),
        .req_valid(req_valid), .req_lin(req_lin), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_phys(rsp_phys),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [63:0] memval(input logic [35:0] a);
        case (a)
            36'h0_0001_0004: return 64'h0000_0000_0002_0001;
            36'h0_0002_000C: return 64'h0000_0000_0ABC_D001;
            36'h0_0001_0008: return 64'h0000_0000_0C00_0081;
            36'h0_0C00_0004: return 64'h0000_0000_0055_5003;
            36'h0_0001_0014: return 64'h0000_0000_0002_1001;
            36'h0_0003_0008: return 64'h0000_0004_0000_0001;
            36'h4_0000_0008: return 64'h0000_0005_0000_0001;
            36'h5_0000_0018: return 64'h0000_0006_789A_B001;
            36'h4_0000_0010: return 64'h0000_0007_0020_0081;
            default: begin
                if (a[35:12] == 24'h000021)
                    return {32'h0, 20'h00300 + {10'h0, a[11:2]}, 12'h001};
                return 64'h0;
            end
        endcase
    endfunction

    // memory model: answers two cycles after each request
    logic [35:0] paddr = '0;
    int          pcnt = 0;
    logic        pend = 1'b0;
    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (pend) begin
            pcnt = pcnt - 1;
            if (pcnt == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = memval(paddr);
                pend       = 1'b0;
            end
        end
        if (mem_req) begin
            pend   = 1'b1;
            paddr  = mem_addr;
            pcnt   = 2;
            nreads = nreads + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_ctl(input logic [31:0] c0, input logic [31:0] c3, input logic [31:0] c4);
        @(negedge clk);
        ctl0_in = c0; ctl3_in = c3; ctl4_in = c4; ctl_wr = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic xlate(input logic [31:0] lin, output logic [35:0] ph, output logic f, output int rd);
        int start, t;
        @(negedge clk);
        t = 0;
        while (!req_ready && t < 200) begin @(negedge clk); t++; end
        start = nreads;
        req_valid = 1'b1; req_lin = lin;
        @(negedge clk);
        req_valid = 1'b0;
        t = 0;
        while (!rsp_valid && t < 200) begin
            if (req_ready) busy_viol++;
            @(negedge clk);
            t++;
        end
        if (!rsp_valid) begin
            errors++; checks++;
            $display("FAIL R11 no response actual=0 expected=1");
        end
        if (req_ready) busy_viol++;
        ph = rsp_phys; f = rsp_fault; rd = nreads - start;
    endtask

    task automatic expect_x(input logic [31:0] lin, input logic [35:0] ep, input logic ef,
                            input int er, input string tag);
        logic [35:0] ph; logic f; int rd;
        xlate(lin, ph, f, rd);
        chk(ph == ep, {tag, " phys"}, 64'(ph), 64'(ep));
        chk(f == ef, {tag, " fault"}, 64'(f), 64'(ef));
        chk(rd == er, {tag, " reads"}, 64'(rd), 64'(er));
    endtask

    typedef struct packed {
        logic [31:0] c0;
        logic [31:0] c4;
        logic [31:0] root;
        logic [31:0] lin;
        logic [35:0] phys;
        logic        flt;
        logic [3:0]  nrd;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{32'h0000_0000, 32'h00, 32'h0001_0000, 32'h8765_4321, 36'h0_8765_4321, 1'b0, 4'd0}, // R1
        '{32'h0000_0000, 32'h30, 32'h0001_0000, 32'h4020_3456, 36'h0_4020_3456, 1'b0, 4'd0}, // R12
        '{32'h8000_0000, 32'h00, 32'h0001_0000, 32'h0040_3ABC, 36'h0_0ABC_DABC, 1'b0, 4'd2}, // R2
        '{32'h8000_0000, 32'h10, 32'h0001_0000, 32'h0080_1234, 36'h0_0C00_1234, 1'b0, 4'd1}, // R3
        '{32'h8000_0000, 32'h00, 32'h0001_0000, 32'h0080_1234, 36'h0_0055_5234, 1'b0, 4'd2}, // R4
        '{32'h8000_0000, 32'h00, 32'h0001_0000, 32'h00C0_5000, 36'h0_0000_0000, 1'b1, 4'd1}, // R7
        '{32'h8000_0000, 32'h00, 32'h0001_0000, 32'h0040_4000, 36'h0_0000_0000, 1'b1, 4'd2}, // R7
        '{32'h8000_0000, 32'h20, 32'h0003_0000, 32'h4020_3456, 36'h6_789A_B456, 1'b0, 4'd3}, // R5
        '{32'h8000_0000, 32'h30, 32'h0003_0000, 32'h4040_0777, 36'h7_0020_0777, 1'b0, 4'd2}, // R6
        '{32'h8000_0000, 32'h20, 32'h0003_0000, 32'hC000_0000, 36'h0_0000_0000, 1'b1, 4'd1}, // R7
        '{32'h8000_0000, 32'h20, 32'h0003_0000, 32'h4040_0777, 36'h0_0000_0000, 1'b1, 4'd3}  // R4
    };
    localparam string VTAG [NV] = '{"R1", "R12", "R2", "R3", "R4", "R7", "R7", "R5", "R6", "R7", "R4"};

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R11 reset ready", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0, "R11 reset rsp_valid", 64'(rsp_valid), 64'd0);
        chk(mem_req == 1'b0, "R1 reset mem_req", 64'(mem_req), 64'd0);
        rst_n = 1'b1;

        // vector table: each entry reloads control values, which also empties the cache
        for (int i = 0; i < NV; i++) begin
            set_ctl(VEC[i].c0, VEC[i].root, VEC[i].c4);
            expect_x(VEC[i].lin, VEC[i].phys, VEC[i].flt, int'(VEC[i].nrd), VTAG[i]);
        end

        // R8: hits, with 4 KB and 4 MB mappings side by side
        set_ctl(32'h8000_0000, 32'h0001_0000, 32'h10);
        expect_x(32'h0040_3ABC, 36'h0_0ABC_DABC, 1'b0, 2, "R8 fill small");
        expect_x(32'h0080_1234, 36'h0_0C00_1234, 1'b0, 1, "R8 fill large");
        expect_x(32'h0040_3ABC, 36'h0_0ABC_DABC, 1'b0, 0, "R8 hit small");
        expect_x(32'h0080_5678, 36'h0_0C00_5678, 1'b0, 0, "R8 hit large offset");
        // R7: faults are not cached
        expect_x(32'h00C0_5000, 36'h0, 1'b1, 1, "R7 fault first");
        expect_x(32'h00C0_5000, 36'h0, 1'b1, 1, "R7 fault repeat");
        // R10: flush and control write both invalidate
        do_flush();
        expect_x(32'h0040_3ABC, 36'h0_0ABC_DABC, 1'b0, 2, "R10 after flush");
        expect_x(32'h0040_3ABC, 36'h0_0ABC_DABC, 1'b0, 0, "R10 refilled");
        set_ctl(32'h8000_0000, 32'h0001_0000, 32'h10);
        expect_x(32'h0040_3ABC, 36'h0_0ABC_DABC, 1'b0, 2, "R10 after ctl write");

        // R9: nine distinct pages, the ninth evicts the first
        set_ctl(32'h8000_0000, 32'h0001_0000, 32'h00);
        for (int p = 0; p < 9; p++)
            expect_x(32'h0140_00AB + (p << 12), (36'(32'h300 + p) << 12) | 36'h0AB, 1'b0, 2, "R9 fill");
        expect_x(32'h0140_80AB, 36'h0_0030_80AB, 1'b0, 0, "R9 newest hits");
        expect_x(32'h0140_10AB, 36'h0_0030_10AB, 1'b0, 0, "R9 second hits");
        expect_x(32'h0140_00AB, 36'h0_0030_00AB, 1'b0, 2, "R9 first evicted");

        // R11: ready never high while a translation was in flight
        chk(busy_viol == 0, "R11 busy ready", 64'(busy_viol), 64'd0);
        summary();
    end
endmodule